// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address of one operand from a compact operand descriptor. The descriptor names an optional base register and an optional index register by 3-bit register numbers, gives a 2-bit scale code for the index, and carries a displacement together with a code that says how wide it is. The unit puts both register numbers on two read ports of the register file. In the same cycle it sign-extends the displacement, shifts the index left by the scale code and adds the three terms. The result is registered and appears one clock later.

Two address sizes are supported. In 32-bit mode the sum wraps modulo 2^32, every scale code is legal, and the displacement may be 8 or 32 bits wide. In 16-bit mode the sum is cut to 16 bits, no scaling is allowed, and the displacement may be 8 or 16 bits wide. Clearing the base-present bit, the index-present bit, or both gives the familiar modes:
- direct: displacement only
- register indirect: base only, no displacement
- based: base plus displacement
- indexed: scaled index plus displacement
- based-indexed: base plus scaled index plus displacement

A descriptor that is not legal for the chosen address size raises an error flag, and the address is then forced to zero.

Top module: `eag_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `ea_valid`, `ea_err` and `ea` are all zero.
- R2: A request accepted on a rising edge with `req_valid` high produces `ea_valid` high in the following cycle. With `req_valid` low, `ea_valid` is low in the following cycle.
- R3: Read port A is addressed by `base_sel` and read port B by `idx_sel`. With the base present, the base register value is added to the displacement.
- R4: In 32-bit mode, the index register value is multiplied by 1, 2, 4 or 8 for scale codes 0, 1, 2 and 3, and added to the other terms.
- R5: A register whose present bit is clear contributes zero. With both registers absent, the address is the extended displacement alone.
- R6: The displacement size code is 0 for none (zero), 1 for 8 bits, 2 for 16 bits and 3 for 32 bits. The chosen low bits are sign-extended, and displacement bits above the chosen width have no effect.
- R7: In 32-bit mode the sum wraps modulo 2^32. In 16-bit mode it wraps modulo 2^16, and `ea[31:16]` is zero.
- R8: `ea_err` is raised in three cases, and `ea` is then zero:
  - 16-bit mode with a non-zero scale code;
  - 16-bit mode with displacement size code 3;
  - 32-bit mode with displacement size code 2.
- R9: While `req_valid` is low, `ea` holds its last value whatever the other inputs do, and `ea_err` is low whenever `ea_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptor valid this cycle |
| mode32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| base_vld | input | 1 | Base register present |
| base_sel | input | 3 | Base register number |
| idx_vld | input | 1 | Index register present |
| idx_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift amount (0..3) |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 32 | Displacement, right-aligned |
| rf_a_sel | output | 3 | Register file read port A number |
| rf_a_data | input | 32 | Register file read port A data |
| rf_b_sel | output | 3 | Register file read port B number |
| rf_b_data | input | 32 | Register file read port B data |
| ea_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| ea_err | output | 1 | Illegal descriptor for the address size |

## Verification
The properties assume that the register file answers both read ports in the same cycle. They also assume that `req_valid`, `mode32` and the descriptor fields are settled before the rising edge that samples them. The bench keeps to this: its register file is a combinational array indexed by the select ports, and it drives all inputs on the falling edge. Every request is held for exactly one cycle, so each sampled result belongs to a single descriptor. Because the bench changes the register contents only between requests, the hold check sees stable register data.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned EAG_AW    = 32;
  localparam int unsigned EAG_RSW   = 3;
  localparam int unsigned EAG_SCW   = 2;
  localparam int unsigned EAG_NARW  = 16;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_B8   = 2'd1,
    DSZ_B16  = 2'd2,
    DSZ_B32  = 2'd3
  } dsz_e;
endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
  import eag_pkg::*;
#(
  parameter int unsigned AW = EAG_AW
) (
  input  logic [1:0]    dsz,
  input  logic [AW-1:0] disp_in,
  output logic [AW-1:0] disp_out
);
  localparam int unsigned W8  = 8;
  localparam int unsigned W16 = 16;

  always_comb begin
    unique case (dsz_e'(dsz))
      DSZ_NONE: disp_out = '0;
      DSZ_B8:   disp_out = {{(AW-W8){disp_in[W8-1]}}, disp_in[W8-1:0]};
      DSZ_B16:  disp_out = {{(AW-W16){disp_in[W16-1]}}, disp_in[W16-1:0]};
      default:  disp_out = disp_in;
    endcase
  end
endmodule

// File: rtl/eag_scaler.sv
module eag_scaler
  import eag_pkg::*;
#(
  parameter int unsigned AW  = EAG_AW,
  parameter int unsigned SCW = EAG_SCW
) (
  input  logic           en,
  input  logic [SCW-1:0] sh,
  input  logic [AW-1:0]  val,
  output logic [AW-1:0]  res
);
  localparam int unsigned NSH = 1 << SCW;

  logic [AW-1:0] shifted [NSH];

  for (genvar gi = 0; gi < NSH; gi++) begin : g_sh
    assign shifted[gi] = val << gi;
  end

  assign res = en ? shifted[sh] : '0;
endmodule

// File: rtl/eag_sum.sv
module eag_sum
  import eag_pkg::*;
#(
  parameter int unsigned AW   = EAG_AW,
  parameter int unsigned NARW = EAG_NARW
) (
  input  logic          wide,
  input  logic [AW-1:0] term_b,
  input  logic [AW-1:0] term_x,
  input  logic [AW-1:0] term_d,
  output logic [AW-1:0] total
);
  localparam logic [AW-1:0] NAR_MASK = {{(AW-NARW){1'b0}}, {NARW{1'b1}}};

  logic [AW-1:0] raw;

  assign raw   = term_b + term_x + term_d;
  assign total = wide ? raw : (raw & NAR_MASK);
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int unsigned AW   = EAG_AW,
  parameter int unsigned RSW  = EAG_RSW,
  parameter int unsigned SCW  = EAG_SCW,
  parameter int unsigned NARW = EAG_NARW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           mode32,
  input  logic           base_vld,
  input  logic [RSW-1:0] base_sel,
  input  logic           idx_vld,
  input  logic [RSW-1:0] idx_sel,
  input  logic [SCW-1:0] scale,
  input  logic [1:0]     disp_sz,
  input  logic [AW-1:0]  disp,
  output logic [RSW-1:0] rf_a_sel,
  input  logic [AW-1:0]  rf_a_data,
  output logic [RSW-1:0] rf_b_sel,
  input  logic [AW-1:0]  rf_b_data,
  output logic           ea_valid,
  output logic [AW-1:0]  ea,
  output logic           ea_err
);
  logic [AW-1:0] term_b, term_x, term_d, sum;
  logic          bad_desc;
  logic          nxt_valid, nxt_err, ea_en;
  logic [AW-1:0] nxt_ea;
  logic          vld_q, err_q;
  logic [AW-1:0] ea_q;

  assign rf_a_sel = base_sel;
  assign rf_b_sel = idx_sel;
  assign term_b   = base_vld ? rf_a_data : '0;

  eag_scaler #(.AW(AW), .SCW(SCW)) u_scl (
    .en  (idx_vld),
    .sh  (scale),
    .val (rf_b_data),
    .res (term_x)
  );

  eag_disp_ext #(.AW(AW)) u_dext (
    .dsz      (disp_sz),
    .disp_in  (disp),
    .disp_out (term_d)
  );

  eag_sum #(.AW(AW), .NARW(NARW)) u_sum (
    .wide   (mode32),
    .term_b (term_b),
    .term_x (term_x),
    .term_d (term_d),
    .total  (sum)
  );

  always_comb begin
    if (mode32) bad_desc = (dsz_e'(disp_sz) == DSZ_B16);
    else        bad_desc = (scale != '0) || (dsz_e'(disp_sz) == DSZ_B32);
  end

  always_comb begin
    nxt_valid = req_valid;
    nxt_err   = req_valid && bad_desc;
    ea_en     = req_valid;
    nxt_ea    = bad_desc ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= nxt_valid;
      err_q <= nxt_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ea_q <= '0;
    else if (ea_en) ea_q <= nxt_ea;
  end

  assign ea_valid = vld_q;
  assign ea_err   = err_q;
  assign ea       = ea_q;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned SCW  = 2,
  parameter int unsigned NARW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           mode32,
  input logic [SCW-1:0] scale,
  input logic [1:0]     disp_sz,
  input logic           ea_valid,
  input logic [AW-1:0]  ea,
  input logic           ea_err
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ea_valid);
  // R7
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode32) |=> (ea[AW-1:NARW] == '0));
  // R8
  err_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode32 && scale != '0) |=> ea_err);
  // R8
  err_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((!mode32 && disp_sz == 2'd3) || (mode32 && disp_sz == 2'd2))) |=> ea_err);
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_err |-> (ea == '0));
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_valid |-> !ea_err);
  // R9
  ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ea));
endmodule

bind eag_unit eag_unit_chk #(.AW(AW), .SCW(SCW), .NARW(NARW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mode32    (mode32),
  .scale     (scale),
  .disp_sz   (disp_sz),
  .ea_valid  (ea_valid),
  .ea        (ea),
  .ea_err    (ea_err)
);

// File: tb/eag_unit_tb.sv
`timescale 1ns/1ps
module eag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, mode32, base_vld, idx_vld;
  logic [2:0]  base_sel, idx_sel, rf_a_sel, rf_b_sel;
  logic [1:0]  scale, disp_sz;
  logic [31:0] disp, rf_a_data, rf_b_data, ea;
  logic        ea_valid, ea_err;
  logic [31:0] regs [8];
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign rf_a_data = regs[rf_a_sel];
  assign rf_b_data = regs[rf_b_sel];

  eag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode32(mode32),
    .base_vld(base_vld), .base_sel(base_sel), .idx_vld(idx_vld),
    .idx_sel(idx_sel), .scale(scale), .disp_sz(disp_sz), .disp(disp),
    .rf_a_sel(rf_a_sel), .rf_a_data(rf_a_data), .rf_b_sel(rf_b_sel),
    .rf_b_data(rf_b_data), .ea_valid(ea_valid), .ea(ea), .ea_err(ea_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(logic m32, logic bv, logic [2:0] bs,
      logic iv, logic [2:0] is, logic [1:0] sc, logic [1:0] dz, logic [31:0] d);
    logic        e;
    logic [31:0] dx, s;
    e = m32 ? (dz == 2'd2) : ((sc != 2'd0) || (dz == 2'd3));
    case (dz)
      2'd0: dx = 32'h0;
      2'd1: dx = {{24{d[7]}}, d[7:0]};
      2'd2: dx = {{16{d[15]}}, d[15:0]};
      default: dx = d;
    endcase
    s = (bv ? regs[bs] : 32'h0) + (iv ? (regs[is] << sc) : 32'h0) + dx;
    if (!m32) s = s & 32'h0000_FFFF;
    if (e) s = 32'h0;
    return {e, s};
  endfunction

  task automatic run_req(string req, logic m32, logic bv, logic [2:0] bs,
      logic iv, logic [2:0] is, logic [1:0] sc, logic [1:0] dz, logic [31:0] d);
    logic [32:0] exp;
    exp = model(m32, bv, bs, iv, is, sc, dz, d);
    @(negedge clk);
    req_valid = 1'b1; mode32 = m32; base_vld = bv; base_sel = bs;
    idx_vld = iv; idx_sel = is; scale = sc; disp_sz = dz; disp = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R2 valid"}, {31'h0, ea_valid}, 32'h1);
    check({req, " addr"}, ea, exp[31:0]);
    check({req, " R8 err"}, {31'h0, ea_err}, {31'h0, exp[32]});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'h0, ea_valid}, 32'h0);
    check("R1 err", {31'h0, ea_err}, 32'h0);
    check("R1 ea", ea, 32'h0);
  endtask

  task automatic t_modes32;
    run_req("R3 based disp8 neg", 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_00F0);
    run_req("R3 reg indirect", 1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 2'd0, 32'h1234_5678);
    run_req("R4 indexed x4 disp32", 1'b1, 1'b0, 3'd0, 1'b1, 3'd3, 2'd2, 2'd3, 32'h0010_0000);
    run_req("R4 based-indexed x8", 1'b1, 1'b1, 3'd1, 1'b1, 3'd3, 2'd3, 2'd1, 32'h0000_0004);
    run_req("R4 based-indexed x2", 1'b1, 1'b1, 3'd4, 1'b1, 3'd5, 2'd1, 2'd3, 32'hFFFF_FFFE);
    run_req("R5 direct", 1'b1, 1'b0, 3'd7, 1'b0, 3'd6, 2'd3, 2'd3, 32'hCAFE_0100);
    run_req("R6 upper disp ignored", 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd1, 32'hABCD_0012);
    run_req("R7 wrap32", 1'b1, 1'b1, 3'd6, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0000_0020);
  endtask

  task automatic t_modes16;
    run_req("R7 wrap16 disp16", 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 2'd0, 2'd2, 32'h0000_0020);
    run_req("R7 wrap16 disp8 neg", 1'b0, 1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_00F0);
    run_req("R5 indexed16 no base", 1'b0, 1'b0, 3'd2, 1'b1, 3'd1, 2'd0, 2'd2, 32'h0000_8001);
    run_req("R6 disp16 sext", 1'b0, 1'b1, 3'd1, 1'b1, 3'd4, 2'd0, 2'd2, 32'h5555_FFFF);
  endtask

  task automatic t_errors;
    run_req("R8 scale in 16", 1'b0, 1'b1, 3'd1, 1'b1, 3'd2, 2'd1, 2'd1, 32'h0000_0004);
    run_req("R8 disp32 in 16", 1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0000_0004);
    run_req("R8 disp16 in 32", 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd2, 32'h0000_0004);
  endtask

  task automatic t_hold;
    logic [32:0] exp;
    exp = model(1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_0008);
    run_req("R9 prime", 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_0008);
    @(negedge clk);
    base_sel = 3'd6; disp = 32'h7777_7777; disp_sz = 2'd3; scale = 2'd3;
    mode32 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 ea held", ea, exp[31:0]);
    check("R9 R2 valid low", {31'h0, ea_valid}, 32'h0);
    check("R9 err low", {31'h0, ea_err}, 32'h0);
  endtask

  initial begin
    regs[0] = 32'h0000_0000; regs[1] = 32'h0000_1000;
    regs[2] = 32'h8000_0040; regs[3] = 32'h0000_0011;
    regs[4] = 32'h0123_4567; regs[5] = 32'h0000_0003;
    regs[6] = 32'hFFFF_FFF0; regs[7] = 32'h0001_FFF0;
    rst_n = 1'b0; req_valid = 1'b0; mode32 = 1'b1; base_vld = 1'b0;
    idx_vld = 1'b0; base_sel = '0; idx_sel = '0; scale = '0;
    disp_sz = '0; disp = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes32();
    t_modes16();
    t_errors();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule